// File: doc/BRIEF.md
# Accumulating Wordline Driver Array

This block is the row-driver stage that sits between the row decoder and the wordlines of a small memory array. In ordinary operation it passes the decoder's one-hot row choice to the wordlines whenever the read/write strobe is high. The block also has an accumulate path. Over a series of cycles, a sticky select bit can be set in chosen rows. A single evaluate cycle then raises all of those rows at once, which gives one concurrent read across several rows.

The select bits live only in the rows that a build-time mask marks as capable. Unmarked rows are plain decoder-gated drivers. Rows whose select bit is clear stay low during the evaluate cycle, so the data they hold is never touched. When the block is neither loading nor evaluating, the array works as normal memory. Selections made earlier survive normal accesses until they are cleared.

Top module: `wl_accum_array`

## Requirements
- R1: After the asynchronous reset is released, no select bit is set. An evaluate cycle right after reset drives every wordline low.
- R2: While `acc_en` and `eval` are both low, `wl_out` equals `row_onehot` when `wl_strobe` is 1 and is all zero when `wl_strobe` is 0.
- R3: A clock edge with `acc_en` high sets the select bit of the capable row addressed by `row_onehot`. The bit stays set on later cycles, so selections made in successive cycles accumulate.
- R4: While `eval` is high, bit i of `wl_out` is 1 in that same cycle exactly when row i's select bit is set. All other bits of `wl_out` are 0.
- R5: While `eval` is high, `wl_strobe` and `row_onehot` have no effect on `wl_out`.
- R6: A clock edge with `acc_clr` high and `acc_en` low clears every select bit.
- R7: When `acc_clr` and `acc_en` are both high at one edge, the only row left selected afterwards is the addressed one.
- R8: A row whose bit in `ACC_MASK` is 0 has no select bit. It never rises during `eval`, even if it was addressed while `acc_en` was high. In normal mode it still drives like any decoded row.
- R9: While `acc_en` is high and `eval` is low (loading), every wordline is low, whatever the strobe does.
- R10: Select bits are unchanged across cycles with `acc_en` and `acc_clr` low, including normal strobed accesses.
- R11: When `eval` and `acc_en` are high in the same cycle, `wl_out` shows the selection held before that edge. The newly addressed row joins from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| row_onehot | input | ROWS | One-hot row choice from the decoder |
| wl_strobe | input | 1 | Normal read/write wordline strobe |
| acc_en | input | 1 | Set the select bit of the addressed row |
| acc_clr | input | 1 | Synchronous clear of all select bits |
| eval | input | 1 | Raise all selected rows together |
| wl_out | output | ROWS | Wordline vector |

## Verification
Two pairs of functions can meet in one cycle. The first pair is clear and set. The bench first builds up a selection in two rows. It then raises `acc_clr` and `acc_en` together with a third row addressed, and it judges the result by a later evaluate cycle, which must show only that third row. The second pair is evaluate and set. `eval` and `acc_en` are driven together, and the bench requires the old selection in that cycle and the enlarged one in the next. An evaluate cycle with a live strobe on an unselected row, and an attempt to select a row outside the mask, cover the overlap of the normal path with the accumulate path.

// File: rtl/wl_accum_pkg.sv
package wl_accum_pkg;
  typedef enum logic [1:0] {
    WL_MODE_NORMAL = 2'd0,
    WL_MODE_LOAD   = 2'd1,
    WL_MODE_EVAL   = 2'd2
  } wl_mode_e;
endpackage

// File: rtl/wl_rst_sync.sv
module wl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wl_mode_ctrl.sv
module wl_mode_ctrl
  import wl_accum_pkg::*;
(
  input  logic     acc_en,
  input  logic     eval,
  output wl_mode_e mode
);
  always_comb begin
    if (eval)        mode = WL_MODE_EVAL;
    else if (acc_en) mode = WL_MODE_LOAD;
    else             mode = WL_MODE_NORMAL;
  end
endmodule

// File: rtl/wl_acc_row.sv
module wl_acc_row
  import wl_accum_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wl_mode_e mode,
  input  logic     row_hit,
  input  logic     strobe,
  input  logic     acc_en,
  input  logic     acc_clr,
  output logic     sel_o,
  output logic     wl_o
);
  logic sel_q;
  logic sel_d;
  logic sel_ce;
  logic set_req;

  assign set_req = acc_en & row_hit;
  assign sel_ce  = acc_clr | set_req;

  always_comb begin
    sel_d = sel_q;
    if (acc_clr) sel_d = 1'b0;
    if (set_req) sel_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= 1'b0;
    else if (sel_ce) sel_q <= sel_d;
  end

  always_comb begin
    case (mode)
      WL_MODE_NORMAL: wl_o = strobe & row_hit;
      WL_MODE_EVAL:   wl_o = sel_q;
      default:        wl_o = 1'b0;
    endcase
  end

  assign sel_o = sel_q;

  // R3
  acc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && row_hit) |=> sel_q);

  // R6
  acc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_clr && !(acc_en && row_hit)) |=> !sel_q);

  // R10
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_clr && !acc_en) |=> $stable(sel_q));
endmodule

// File: rtl/wl_accum_array.sv
module wl_accum_array
  import wl_accum_pkg::*;
#(
  parameter int               ROWS       = 8,
  parameter logic [ROWS-1:0]  ACC_MASK   = 8'hEF,
  parameter int               SYNC_DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ROWS-1:0] row_onehot,
  input  logic            wl_strobe,
  input  logic            acc_en,
  input  logic            acc_clr,
  input  logic            eval,
  output logic [ROWS-1:0] wl_out
);
  localparam logic [ROWS-1:0] PLAIN_MASK = ~ACC_MASK;

  logic            rst_sync_n;
  wl_mode_e        mode;
  logic [ROWS-1:0] sel_vec;

  wl_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wl_mode_ctrl u_mode (
    .acc_en (acc_en),
    .eval   (eval),
    .mode   (mode)
  );

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    if (ACC_MASK[i]) begin : g_acc
      wl_acc_row u_row (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .mode    (mode),
        .row_hit (row_onehot[i]),
        .strobe  (wl_strobe),
        .acc_en  (acc_en),
        .acc_clr (acc_clr),
        .sel_o   (sel_vec[i]),
        .wl_o    (wl_out[i])
      );
    end else begin : g_plain
      assign sel_vec[i] = 1'b0;
      assign wl_out[i]  = (mode == WL_MODE_NORMAL) & wl_strobe & row_onehot[i];
    end
  end

  // R9
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_en && !eval) |-> (wl_out == '0));

  // R4
  eval_sel_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    eval |-> (wl_out == sel_vec));

  // R8
  plain_eval_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    eval |-> ((wl_out & PLAIN_MASK) == '0));

  // R2
  normal_decode_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!acc_en && !eval) |-> ((wl_out & ~row_onehot) == '0));

  // R11
  eval_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eval && acc_en && !acc_clr && ((row_onehot & ACC_MASK) != '0)) |=> $countones(sel_vec) >= 1);
endmodule

// File: tb/wl_accum_array_test.sv
module wl_accum_array_test;
  localparam int ROWS = 8;
  localparam logic [ROWS-1:0] MASK = 8'hEF;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [ROWS-1:0] row_onehot;
  logic            wl_strobe, acc_en, acc_clr, eval;
  logic [ROWS-1:0] wl_out;

  int checks = 0;
  int failures = 0;
  logic [ROWS-1:0] m_sel;

  wl_accum_array #(.ROWS(ROWS), .ACC_MASK(MASK)) uut (
    .clk(clk), .rst_n(rst_n), .row_onehot(row_onehot), .wl_strobe(wl_strobe),
    .acc_en(acc_en), .acc_clr(acc_clr), .eval(eval), .wl_out(wl_out)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [ROWS-1:0] act, input logic [ROWS-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic clr, input logic ev,
                       input logic stb, input logic [ROWS-1:0] oh);
    @(negedge clk);
    acc_en = en; acc_clr = clr; eval = ev; wl_strobe = stb; row_onehot = oh;
    #1;
  endtask

  task automatic select_row(input int r);
    drive(1'b1, 1'b0, 1'b0, 1'b1, ROWS'(1) << r);
    chk("R9 load keeps wordlines low", wl_out, '0);
    m_sel = m_sel | ((ROWS'(1) << r) & MASK);
  endtask

  task automatic look(input string req);
    drive(1'b0, 1'b0, 1'b1, 1'b0, '0);
    chk(req, wl_out, m_sel);
  endtask

  task automatic t_reset;
    look("R1 eval after reset");
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h01);
    chk("R1 idle after reset", wl_out, '0);
  endtask

  task automatic t_normal;
    for (int r = 0; r < ROWS; r++) begin
      drive(1'b0, 1'b0, 1'b0, 1'b1, ROWS'(1) << r);
      chk("R2 strobed decode", wl_out, ROWS'(1) << r);
    end
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h20);
    chk("R2 strobe low", wl_out, '0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h10);
    chk("R8 plain row in normal mode", wl_out, 8'h10);
  endtask

  task automatic t_accumulate;
    select_row(1);
    select_row(6);
    look("R3 R4 two rows accumulated");
    drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h04);
    chk("R5 strobe ignored during eval", wl_out, m_sel);
  endtask

  task automatic t_persist;
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h02);
    chk("R10 normal access with selection held", wl_out, 8'h02);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h80);
    look("R10 selection survives normal access");
  endtask

  task automatic t_clear;
    drive(1'b0, 1'b1, 1'b0, 1'b0, '0);
    m_sel = '0;
    look("R6 clear empties selection");
  endtask

  task automatic t_clr_and_set;
    select_row(0);
    select_row(5);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 8'h80);
    m_sel = 8'h80;
    look("R7 clear plus set leaves only new row");
  endtask

  task automatic t_plain;
    drive(1'b0, 1'b1, 1'b0, 1'b0, '0);
    m_sel = '0;
    select_row(4);
    select_row(2);
    look("R8 plain row stays low in eval");
    chk("R8 plain row bit", wl_out & 8'h10, '0);
  endtask

  task automatic t_eval_and_set;
    drive(1'b1, 1'b0, 1'b1, 1'b0, 8'h08);
    chk("R11 old selection in shared cycle", wl_out, m_sel);
    m_sel = m_sel | 8'h08;
    look("R11 new row joins next cycle");
  endtask

  initial begin
    rst_n = 1'b0;
    row_onehot = '0; wl_strobe = 1'b0; acc_en = 1'b0; acc_clr = 1'b0; eval = 1'b0;
    m_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_normal();
    t_accumulate();
    t_persist();
    t_clear();
    t_clr_and_set();
    t_plain();
    t_eval_and_set();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule